// File: doc/BRIEF.md
# Countdown Timer with Masked Interrupt Status

This block is a 32-bit down-counter together with a small interrupt controller. The counter is kept as a low and a high 16-bit half, and the host can read and write each half. Two command bits run and halt it. While it runs, it steps down by one on every tick of a 5 MHz enable. A parameterized prescaler makes that enable from the system clock. When a tick arrives with the count at zero, the count wraps to all ones, a timer-complete status bit is raised and counting goes on.

The interrupt side holds a 16-bit status word and a 16-bit enable mask. Other blocks set status bits through single-cycle set pulses. The host clears a status bit by writing one to it. A single level interrupt output is high while any enabled status bit is set.

The host reaches five 16-bit registers through a simple write strobe with an address. Reads are combinational from the address: command at 0, mask at 1, status at 2, count low at 3 and count high at 4. Any other address reads as zero.

Top module: `cdtimer_irq`

## Requirements
- R1: After reset the command register reads 0x0010 (halted bit 4 set, running bit 5 clear), and the count, mask, status and `irq` are all zero.
- R2: Writing the command register with bit 5 set starts the timer: bit 5 reads 1 and bit 4 reads 0. Writing it with bit 4 set halts the timer: bit 4 reads 1 and bit 5 reads 0. If both bits are set in one write, halt wins. A write with neither bit set changes nothing.
- R3: While running, the count decreases by exactly one every TICK_DIV clock cycles. The first decrease comes TICK_DIV cycles after the start write.
- R4: While halted, the count holds its value and reads return that value.
- R5: A tick taken at count zero loads 0xFFFF into both halves and sets status bit 7, and the count keeps decreasing afterwards.
- R6: A write to the low half (address 3) or the high half (address 4) replaces that half only, and the countdown restarts its full TICK_DIV period from the written value.
- R7: A mask write stores bits 14:0 and always leaves bit 15 at 0.
- R8: A status write clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R9: A `statusSet` bit sets the matching status bit. If it arrives in the same cycle as a host clear of that bit, the bit ends up set.
- R10: `irq` is high exactly when the bitwise AND of mask and status is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostAddr | input | 3 | Register address for reads and writes |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Read data for hostAddr (combinational) |
| statusSet | input | 16 | Single-cycle set pulses from other blocks |
| irq | output | 1 | Level interrupt request |

## Verification
Two updates can hit the same status bit in one cycle. A hardware set pulse can coincide with a host write-one-to-clear. The timer's own underflow can also coincide with a host write to the status word. The bench provokes the first case directly: it pulses a set and writes a clear to the same bit at the same edge, then requires the bit to read back as set. A random phase then mixes set pulses, mask writes and clear writes on the same cycles, and compares status and `irq` against a bench model after every edge.

// File: rtl/cdtimer_pkg.sv
package cdtimer_pkg;
  localparam int ADDR_W = 3;
  localparam int REG_W  = 16;

  localparam logic [ADDR_W-1:0] ADDR_CMD    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNTLO  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CNTHI  = 3'd4;

  localparam int CMD_HALT_BIT  = 4;
  localparam int CMD_START_BIT = 5;
  localparam int STAT_TIMER_BIT = 7;
  localparam int MASK_LOCK_BIT  = 15;

  typedef struct packed {
    logic tick;
    logic wrLo;
    logic wrHi;
    logic wrMask;
    logic wrStatus;
  } ctrlStrobes_t;
endpackage

// File: rtl/cdtimer_ctrl.sv
module cdtimer_ctrl
  import cdtimer_pkg::*;
#(
  parameter int TICK_DIV = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [REG_W-1:0]  hostWrData,
  output logic              runFlag,
  output logic              stopFlag,
  output ctrlStrobes_t      strb
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic cmdWr, startCmd, haltCmd, restartPre;

  assign cmdWr    = hostWrEn && (hostAddr == ADDR_CMD);
  assign haltCmd  = cmdWr && hostWrData[CMD_HALT_BIT];
  assign startCmd = cmdWr && hostWrData[CMD_START_BIT] && !hostWrData[CMD_HALT_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runFlag  <= 1'b0;
      stopFlag <= 1'b1;
    end else if (haltCmd) begin
      runFlag  <= 1'b0;
      stopFlag <= 1'b1;
    end else if (startCmd) begin
      runFlag  <= 1'b1;
      stopFlag <= 1'b0;
    end
  end

  assign strb.wrLo     = hostWrEn && (hostAddr == ADDR_CNTLO);
  assign strb.wrHi     = hostWrEn && (hostAddr == ADDR_CNTHI);
  assign strb.wrMask   = hostWrEn && (hostAddr == ADDR_MASK);
  assign strb.wrStatus = hostWrEn && (hostAddr == ADDR_STATUS);

  assign restartPre = startCmd || haltCmd || strb.wrLo || strb.wrHi;

  generate
    if (TICK_DIV > 1) begin : g_prescale
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || restartPre || !runFlag) begin
          preCnt <= '0;
        end else if (preCnt == PRE_LAST) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
      assign strb.tick = runFlag && !restartPre && (preCnt == PRE_LAST);
    end else begin : g_direct
      assign strb.tick = runFlag && !restartPre;
    end
  endgenerate
endmodule

// File: rtl/cdtimer_dpath.sv
module cdtimer_dpath
  import cdtimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [REG_W-1:0]  hostWrData,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [REG_W-1:0]  statusSet,
  input  logic              runFlag,
  input  logic              stopFlag,
  output logic [REG_W-1:0]  hostRdData,
  output logic              irq,
  output logic [CNT_W-1:0]  countVal,
  output logic [REG_W-1:0]  maskQ,
  output logic [REG_W-1:0]  statusQ
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] countNext;
  logic             underflow;
  logic [REG_W-1:0] clrBits, timerSet, statusNext;

  assign underflow = strb.tick && (countVal == '0);

  always_comb begin
    countNext = countVal;
    if (strb.tick) begin
      countNext = underflow ? '1 : countVal - 1'b1;
    end
    if (strb.wrLo) countNext[HALF-1:0]     = hostWrData[HALF-1:0];
    if (strb.wrHi) countNext[CNT_W-1:HALF] = hostWrData[HALF-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) countVal <= '0;
    else       countVal <= countNext;
  end

  always_comb begin
    clrBits  = strb.wrStatus ? (hostWrData & statusQ) : '0;
    timerSet = '0;
    timerSet[STAT_TIMER_BIT] = underflow;
    statusNext = (statusQ & ~clrBits) | statusSet | timerSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= statusNext;
      if (strb.wrMask) begin
        maskQ <= hostWrData & ~(REG_W'(1) << MASK_LOCK_BIT);
      end
    end
  end

  assign irq = |(maskQ & statusQ);

  always_comb begin
    hostRdData = '0;
    case (hostAddr)
      ADDR_CMD: begin
        hostRdData[CMD_START_BIT] = runFlag;
        hostRdData[CMD_HALT_BIT]  = stopFlag;
      end
      ADDR_MASK:   hostRdData = maskQ;
      ADDR_STATUS: hostRdData = statusQ;
      ADDR_CNTLO:  hostRdData = countVal[HALF-1:0];
      ADDR_CNTHI:  hostRdData = countVal[CNT_W-1:HALF];
      default:     hostRdData = '0;
    endcase
  end
endmodule

// File: rtl/cdtimer_irq.sv
module cdtimer_irq
  import cdtimer_pkg::*;
#(
  parameter int TICK_DIV = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [2:0]  hostAddr,
  input  logic [15:0] hostWrData,
  output logic [15:0] hostRdData,
  input  logic [15:0] statusSet,
  output logic        irq
);
  localparam int CNT_W = 2 * REG_W;

  ctrlStrobes_t     strb;
  logic             runFlag, stopFlag;
  logic [CNT_W-1:0] countVal;
  logic [REG_W-1:0] maskQ, statusQ;

  cdtimer_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .runFlag(runFlag), .stopFlag(stopFlag), .strb(strb)
  );

  cdtimer_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWrData(hostWrData),
    .hostAddr(hostAddr), .statusSet(statusSet), .runFlag(runFlag),
    .stopFlag(stopFlag), .hostRdData(hostRdData), .irq(irq),
    .countVal(countVal), .maskQ(maskQ), .statusQ(statusQ)
  );
endmodule

// File: rtl/cdtimer_irq_checker.sv
module cdtimer_irq_checker (
  input logic        clk,
  input logic        rstN,
  input logic        hostWrEn,
  input logic [15:0] statusSet,
  input logic        runFlag,
  input logic        stopFlag,
  input logic [31:0] countVal,
  input logic [15:0] maskQ,
  input logic [15:0] statusQ
);
  a_r2_run_halt_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    runFlag != stopFlag);

  a_r4_halted_holds: assert property (@(posedge clk) disable iff (!rstN)
    (stopFlag && !hostWrEn) |=> $stable(countVal));

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (runFlag && !hostWrEn) |=> (countVal == $past(countVal)
      || countVal == $past(countVal) - 32'd1
      || ($past(countVal) == 32'd0 && countVal == 32'hFFFF_FFFF)));

  a_r5_wrap_flags: assert property (@(posedge clk) disable iff (!rstN)
    ($past(countVal) == 32'd0 && countVal == 32'hFFFF_FFFF) |-> statusQ[7]);

  a_r7_mask_top_clear: assert property (@(posedge clk) disable iff (!rstN)
    maskQ[15] == 1'b0);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (statusSet != 16'd0) |=> ((statusQ & $past(statusSet)) == $past(statusSet)));
endmodule

bind cdtimer_irq cdtimer_irq_checker u_checker (.*);

// File: tb/cdtimer_irq_bench.sv
module cdtimer_irq_bench;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [2:0]  hostAddr = 3'd0;
  logic [15:0] hostWrData = 16'd0;
  logic [15:0] statusSet = 16'd0;
  logic [15:0] hostRdData;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cdtimer_irq #(.TICK_DIV(DIV)) u_cdtimer_irq (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .statusSet(statusSet), .irq(irq)
  );

  function automatic logic [15:0] modelStatus(logic [15:0] cur, logic [15:0] set,
                                              bit wr, logic [15:0] data);
    logic [15:0] clr;
    clr = wr ? (data & cur) : 16'd0;
    return (cur & ~clr) | set;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] a, output logic [15:0] v);
    hostAddr = a;
    #0.5;
    v = hostRdData;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, mdlStat, mdlMask;
    void'($urandom(32'd7341));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    readReg(3'd0, v); check("R1 cmd", v, 16'h0010);
    readReg(3'd1, v); check("R1 mask", v, 0);
    readReg(3'd2, v); check("R1 status", v, 0);
    readReg(3'd3, v); check("R1 cntlo", v, 0);
    readReg(3'd4, v); check("R1 cnthi", v, 0);
    check("R1 irq", irq, 0);

    // R4 halted holds
    writeReg(3'd3, 16'd5);
    writeReg(3'd4, 16'h0001);
    idle(20);
    readReg(3'd3, v); check("R4 lo hold", v, 16'd5);
    readReg(3'd4, v); check("R4 hi hold", v, 16'd1);

    // R2 start, R3 tick spacing
    writeReg(3'd0, 16'h0020);
    readReg(3'd0, v); check("R2 start", v, 16'h0020);
    idle(DIV - 1);
    readReg(3'd3, v); check("R3 before tick", v, 16'd5);
    idle(1);
    readReg(3'd3, v); check("R3 first tick", v, 16'd4);
    idle(DIV);
    readReg(3'd3, v); check("R3 second tick", v, 16'd3);

    // R6 write restarts; R5 underflow
    writeReg(3'd4, 16'h0000);
    writeReg(3'd3, 16'd1);
    idle(DIV - 1);
    readReg(3'd3, v); check("R6 restart period", v, 16'd1);
    idle(1);
    readReg(3'd3, v); check("R6 counts from written", v, 16'd0);
    idle(DIV);
    readReg(3'd3, v); check("R5 lo reload", v, 16'hFFFF);
    readReg(3'd4, v); check("R5 hi reload", v, 16'hFFFF);
    readReg(3'd2, v); check("R5 status bit7", v, 16'h0080);
    idle(DIV);
    readReg(3'd3, v); check("R5 continues", v, 16'hFFFE);

    // R2 halt, both bits -> halt
    writeReg(3'd0, 16'h0010);
    readReg(3'd0, v); check("R2 halt", v, 16'h0010);
    idle(3 * DIV);
    readReg(3'd3, v); check("R4 halted after run", v, 16'hFFFE);
    writeReg(3'd0, 16'h0020);
    writeReg(3'd0, 16'h0030);
    readReg(3'd0, v); check("R2 both halt wins", v, 16'h0010);
    writeReg(3'd0, 16'h0000);
    readReg(3'd0, v); check("R2 no-op cmd", v, 16'h0010);

    // R7 mask bit 15, R10 irq
    check("R10 irq masked off", irq, 0);
    writeReg(3'd1, 16'hFFFF);
    readReg(3'd1, v); check("R7 mask msb", v, 16'h7FFF);
    check("R10 irq on", irq, 1);

    // R8 W1C
    writeReg(3'd2, 16'h0000);
    readReg(3'd2, v); check("R8 zero write", v, 16'h0080);
    writeReg(3'd2, 16'h0080);
    readReg(3'd2, v); check("R8 clear", v, 16'h0000);
    check("R10 irq off", irq, 0);

    // R9 set vs clear same cycle
    @(negedge clk);
    statusSet = 16'h0008;
    @(posedge clk); @(negedge clk);
    statusSet = 16'h0000;
    hostAddr = 3'd2; hostWrData = 16'h0008; hostWrEn = 1'b1; statusSet = 16'h0008;
    @(posedge clk); @(negedge clk);
    hostWrEn = 1'b0; statusSet = 16'h0000;
    readReg(3'd2, v); check("R9 set wins", v, 16'h0008);

    // R8/R9/R10 random mix against model (timer halted)
    readReg(3'd2, mdlStat);
    readReg(3'd1, mdlMask);
    for (int i = 0; i < 400; i++) begin
      logic [15:0] s, d;
      logic [2:0] a;
      bit w;
      s = ($urandom % 4 == 0) ? 16'($urandom) : 16'd0;
      w = ($urandom % 2) == 1;
      a = ($urandom % 3 == 0) ? 3'd1 : 3'd2;
      d = 16'($urandom);
      @(negedge clk);
      statusSet = s; hostWrEn = w; hostAddr = a; hostWrData = d;
      @(posedge clk); @(negedge clk);
      statusSet = 16'd0; hostWrEn = 1'b0;
      mdlStat = modelStatus(mdlStat, s, w && a == 3'd2, d);
      if (w && a == 3'd1) mdlMask = d & 16'h7FFF;
      readReg(3'd2, v); check("R9 random status", v, mdlStat);
      check("R10 random irq", irq, |(mdlMask & mdlStat));
    end
    readReg(3'd1, v); check("R7 random mask", v, mdlMask);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule